// File: doc/BRIEF.md
# Controller Operating Mode Sequencer

This block holds the operating mode of a bus communication controller. Software supplies request bits: a halt request, a freeze enable, a module disable, doze and stop low-power requests, and listen-only and loop-back selections. From these the block works out a target mode. The modes are normal, listen-only, loop-back, freeze, disable, doze and stop.

A change of mode is offered to the protocol engine through a change-request flag and a target-mode code. The change is committed only when the engine acknowledges it. The committed mode drives four outputs:

- a not-ready status;
- an enable that lets the protocol engine receive and transmit;
- a write permission for the error counter register;
- a masked wake-up interrupt.

The block leaves reset in freeze mode. Software therefore has to clear the halt request before any bus traffic can flow.

Top module: `ctl_mode_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the committed mode is freeze. At that point not_ready=1, pe_enable=0 and ecr_wr_en=1.
- R2: The committed mode changes only on a clock edge where pe_ack=1 and chg_req=1. Without pe_ack it holds, however long a change stays pending.
- R3: Freeze is requested only when halt_req=1 and frz_en=1 together. halt_req alone leaves a running mode running.
- R4: pe_enable is 0 whenever the mode is not a run mode, and also whenever halt_req and frz_en are both 1. This holds even before the acknowledge, so no reception or transmission can start while halted.
- R5: A freeze request is refused while the committed mode is disable, doze or stop. When the low-power request drops, the block first returns to a run mode, and the still-pending freeze is taken on the next acknowledged change.
- R6: ecr_wr_en is 1 only in freeze mode, so the error counter is read-only in every other mode.
- R7: not_ready is 1 in freeze, disable, doze and stop, and 0 in normal, listen-only and loop-back. It changes only on an acknowledged commit, never on the request itself.
- R8: Low-power requests outrank freeze and each other in the order disable, then stop, then doze.
- R9: With no low-power or freeze request, loop-back outranks listen-only, which outranks normal.
- R10: wake_irq is wake_evt gated by wake_msk=1, and only while the mode is doze or stop. It is 0 otherwise.
- R11: chg_req is 1 exactly when the target differs from the committed mode. After an acknowledged commit, the mode equals the target offered in that cycle.
- R12: Mode codes on mode_o and tgt_mode_o are: 0 normal, 1 listen-only, 2 loop-back, 3 freeze, 4 disable, 5 doze, 6 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Software halt request |
| frz_en | input | 1 | Freeze enable; freeze needs this and halt_req |
| mdis_req | input | 1 | Module disable request |
| doze_req | input | 1 | Doze low-power request |
| stop_req | input | 1 | Stop low-power request |
| listen_req | input | 1 | Listen-only selection |
| lpbk_req | input | 1 | Loop-back selection |
| pe_ack | input | 1 | Protocol engine acknowledge of the offered change |
| wake_msk | input | 1 | Wake-up interrupt enable (1 enables) |
| wake_evt | input | 1 | Wake-up event from the bus |
| mode_o | output | 3 | Committed mode code |
| tgt_mode_o | output | 3 | Target mode offered to the protocol engine |
| chg_req | output | 1 | A mode change is pending acknowledge |
| not_ready | output | 1 | Module is in freeze, disable, doze or stop |
| pe_enable | output | 1 | Protocol engine may receive and transmit |
| ecr_wr_en | output | 1 | Error counter register is writable |
| wake_irq | output | 1 | Masked wake-up interrupt |

## Verification
A freeze request and a low-power request can be raised in the same cycle. The bench drives halt_req, frz_en and doze_req together from normal mode and acknowledges once. It checks that doze is committed rather than freeze, and that pe_enable is already low before the acknowledge. It then drops doze_req while the freeze request stays up. The next commit must land in normal mode, and only the following commit in freeze.

// File: rtl/ctl_mode_seq.sv
module ctl_mode_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       frz_en,
  input  logic       mdis_req,
  input  logic       doze_req,
  input  logic       stop_req,
  input  logic       listen_req,
  input  logic       lpbk_req,
  input  logic       pe_ack,
  input  logic       wake_msk,
  input  logic       wake_evt,
  output logic [2:0] mode_o,
  output logic [2:0] tgt_mode_o,
  output logic       chg_req,
  output logic       not_ready,
  output logic       pe_enable,
  output logic       ecr_wr_en,
  output logic       wake_irq
);

  typedef enum logic [2:0] {
    M_NORM = 3'd0,
    M_LSTN = 3'd1,
    M_LPBK = 3'd2,
    M_FRZ  = 3'd3,
    M_DIS  = 3'd4,
    M_DOZE = 3'd5,
    M_STOP = 3'd6
  } mode_e;

  mode_e cur, nxt, run_m;
  logic  lp_cur, lp_req, frz_req;

  assign lp_cur  = (cur == M_DIS) || (cur == M_DOZE) || (cur == M_STOP);
  assign lp_req  = mdis_req | doze_req | stop_req;
  assign frz_req = halt_req & frz_en;
  assign run_m   = lpbk_req ? M_LPBK : (listen_req ? M_LSTN : M_NORM);

  always_comb begin
    if (mdis_req)                nxt = M_DIS;
    else if (stop_req)           nxt = M_STOP;
    else if (doze_req)           nxt = M_DOZE;
    else if (frz_req && !lp_cur) nxt = M_FRZ;
    else                         nxt = run_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cur <= M_FRZ;
    else if (pe_ack && chg_req) cur <= nxt;
  end

  assign chg_req    = (nxt != cur);
  assign mode_o     = cur;
  assign tgt_mode_o = nxt;
  assign not_ready  = (cur == M_FRZ) || lp_cur;
  assign pe_enable  = !not_ready && !frz_req;
  assign ecr_wr_en  = (cur == M_FRZ);
  assign wake_irq   = wake_msk & wake_evt & ((cur == M_DOZE) || (cur == M_STOP));

  // R1
  a_r1_reset_freeze: assert property (@(posedge clk) !rst_n |=> cur == M_FRZ);
  a_r2_hold_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_ack |=> $stable(cur));
  a_r3_freeze_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_ack && !(halt_req && frz_en)) |=> cur != M_FRZ);
  a_r4_gate_in_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && frz_en) |-> !pe_enable);
  a_r5_no_freeze_from_lp: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_cur && pe_ack) |=> cur != M_FRZ);
  a_r6_ecr_only_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_wr_en |-> (not_ready && !pe_enable));
  a_r7_nr_fall_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(not_ready) |-> $past(pe_ack));
  a_r7_nr_rise_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(not_ready) |-> $past(pe_ack));
  a_r8_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_ack && mdis_req) |=> cur == M_DIS);
  a_r9_loopback_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_ack && !lp_req && !frz_req && lpbk_req) |=> cur == M_LPBK);
  a_r10_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (wake_msk && not_ready && !ecr_wr_en));
  a_r11_commit_target: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_ack && chg_req) |=> mode_o == $past(tgt_mode_o));

endmodule

// File: tb/ctl_mode_seq_tb.sv
`timescale 1ns/1ps
module ctl_mode_seq_tb;
  logic clk = 1'b0;
  logic rst_n, halt_req, frz_en, mdis_req, doze_req, stop_req, listen_req, lpbk_req;
  logic pe_ack, wake_msk, wake_evt;
  logic [2:0] mode_o, tgt_mode_o;
  logic chg_req, not_ready, pe_enable, ecr_wr_en, wake_irq;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctl_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .frz_en(frz_en), .mdis_req(mdis_req),
    .doze_req(doze_req), .stop_req(stop_req), .listen_req(listen_req), .lpbk_req(lpbk_req),
    .pe_ack(pe_ack), .wake_msk(wake_msk), .wake_evt(wake_evt), .mode_o(mode_o),
    .tgt_mode_o(tgt_mode_o), .chg_req(chg_req), .not_ready(not_ready), .pe_enable(pe_enable),
    .ecr_wr_en(ecr_wr_en), .wake_irq(wake_irq));

  // {halt, frz_en, mdis, doze, stop, listen, lpbk, expected mode[2:0]}
  localparam logic [9:0] VEC [0:12] = '{
    {7'b1100000, 3'd3}, {7'b0100000, 3'd0}, {7'b1000000, 3'd0}, {7'b0000010, 3'd1},
    {7'b0000011, 3'd2}, {7'b1100001, 3'd3}, {7'b1101000, 3'd5}, {7'b1100000, 3'd0},
    {7'b1100000, 3'd3}, {7'b0001100, 3'd6}, {7'b0010100, 3'd4}, {7'b0000010, 3'd1},
    {7'b0000000, 3'd0}};

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [6:0] v);
    {halt_req, frz_en, mdis_req, doze_req, stop_req, listen_req, lpbk_req} = v;
  endtask

  task automatic ack_once();
    @(negedge clk) pe_ack = 1'b1;
    @(negedge clk) pe_ack = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; pe_ack = 1'b0; wake_msk = 1'b0; wake_evt = 1'b0;
    set_in(7'b1100000);
    repeat (3) @(negedge clk);
    chk("R1 mode in reset", int'(mode_o), 3);
    chk("R1 not_ready in reset", int'(not_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after reset", int'(mode_o), 3);
    chk("R1 pe_enable after reset", int'(pe_enable), 0);
    chk("R1 ecr_wr_en after reset", int'(ecr_wr_en), 1);

    // table: R3 R5 R8 R9 R12 R6 R7 R4
    for (int i = 0; i < 13; i++) begin
      logic [6:0] v;
      int em;
      v = VEC[i][9:3];
      em = int'(VEC[i][2:0]);
      @(negedge clk) set_in(v); pe_ack = 1'b1;
      @(negedge clk) pe_ack = 1'b0;
      chk("R12 mode after ack", int'(mode_o), em);
      chk("R7 not_ready", int'(not_ready), (em >= 3) ? 1 : 0);
      chk("R4 pe_enable", int'(pe_enable), (em < 3 && !(v[6] && v[5])) ? 1 : 0);
      chk("R6 ecr_wr_en", int'(ecr_wr_en), (em == 3) ? 1 : 0);
    end

    // R2 / R11 / R4: pending freeze without acknowledge
    @(negedge clk) set_in(7'b1100000);
    @(negedge clk);
    chk("R11 chg_req pending", int'(chg_req), 1);
    chk("R11 tgt_mode", int'(tgt_mode_o), 3);
    chk("R4 pe_enable gated before ack", int'(pe_enable), 0);
    chk("R7 not_ready before ack", int'(not_ready), 0);
    repeat (4) @(negedge clk);
    chk("R2 mode held without ack", int'(mode_o), 0);
    ack_once();
    chk("R2 mode after ack", int'(mode_o), 3);
    chk("R11 chg_req after commit", int'(chg_req), 0);

    // R7 / R6: leaving freeze waits for ack
    @(negedge clk) set_in(7'b0100000);
    repeat (2) @(negedge clk);
    chk("R7 not_ready held before ack", int'(not_ready), 1);
    chk("R6 ecr_wr_en held before ack", int'(ecr_wr_en), 1);
    ack_once();
    chk("R7 not_ready after ack", int'(not_ready), 0);
    chk("R6 ecr_wr_en outside freeze", int'(ecr_wr_en), 0);

    // same cycle: freeze and doze together, then wake
    @(negedge clk) set_in(7'b1101000); pe_ack = 1'b1;
    @(negedge clk) pe_ack = 1'b0;
    chk("R8 doze beats freeze", int'(mode_o), 5);
    wake_msk = 1'b1; wake_evt = 1'b1;
    @(negedge clk);
    chk("R10 wake_irq in doze", int'(wake_irq), 1);
    wake_msk = 1'b0;
    @(negedge clk);
    chk("R10 wake_irq masked", int'(wake_irq), 0);
    wake_msk = 1'b1;
    @(negedge clk) set_in(7'b1100000); pe_ack = 1'b1;
    @(negedge clk) pe_ack = 1'b0;
    chk("R5 freeze refused from low-power", int'(mode_o), 0);
    chk("R10 wake_irq in run mode", int'(wake_irq), 0);
    chk("R5 freeze still pending", int'(tgt_mode_o), 3);
    ack_once();
    chk("R5 pending freeze taken", int'(mode_o), 3);
    wake_msk = 1'b0; wake_evt = 1'b0;

    // R8: disable beats stop and doze; R9: loop-back beats listen
    @(negedge clk) set_in(7'b0011100); pe_ack = 1'b1;
    @(negedge clk) pe_ack = 1'b0;
    chk("R8 disable wins", int'(mode_o), 4);
    @(negedge clk) set_in(7'b0000011); pe_ack = 1'b1;
    @(negedge clk) pe_ack = 1'b0;
    chk("R9 loop-back wins", int'(mode_o), 2);

    // R1: reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset mode", int'(mode_o), 3);
    chk("R1 mid-run ecr_wr_en", int'(ecr_wr_en), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule